// File: doc/BRIEF.md
# Event-Driven Convolution Array Controller

This block turns a stream of address events into a stream of address events through a grid of spiking integrators. Each incoming event carries an (x, y) position in an input plane that is larger than the integrator grid. The grid sits at the centre of that plane. When an event arrives, the controller latches the address and acknowledges it. It then works out where a stored signed kernel lands relative to the grid and copies the overlapping part of the kernel into per-pixel weight registers, one grid row per clock. A single integration step then adds every staged weight into its pixel's accumulator, and the staged weights are cleared in the same step.

Accumulators saturate at plus and minus a threshold. A pixel that sits at the positive threshold fires. Firing pixels are serialized onto one output port by a fixed-priority picker and presented with a valid/ready handshake. A pixel's accumulator returns to zero when its output event is taken. New input events are held off while any output event is pending. The kernel is loaded through a simple write port.

Top module: `conv_event_array`

## Requirements
- R1: The kernel write port stores a KW_WGT-bit two's-complement weight at kernel row `kw_row`, column `kw_col` when `kw_en` is high. After reset every weight is zero, so events cause no firing until weights are written.
- R2: An input event is accepted on a clock edge where `ev_req` is high, the controller is idle, no output event is pending and no acknowledge was given in the previous cycle. `ev_ack` is a one-cycle pulse in the cycle right after acceptance, and the address seen at that edge is the one processed. While `out_valid` is high, no event is acknowledged.
- R3: With OFF = (2^IN_AW − ARR_W)/2 and KC = KER_W/2, an event at (x, y) adds kernel weight [row py+OFF−y+KC][column px+OFF−x+KC] to grid pixel (px, py).
- R4: Kernel entries whose target falls outside the grid are dropped and never wrap to the opposite edge.
- R5: From one acceptance to the next, with `ev_req` held high, there are 3+n cycles, where n is the number of grid rows the kernel overlaps. When n is zero, there are 2 cycles.
- R6: Each accumulator is clamped to the range [−THRESH, +THRESH]. Negative weights cannot push it below −THRESH.
- R7: A pixel at +THRESH presents an output event until that event is taken (`out_valid` and `out_ready` high at an edge). Its accumulator is then zero, so the same pixel is not presented again without new input.
- R8: Among firing pixels, the lowest row is presented first, and within a row the lowest column. `out_y` is the grid row and `out_x` the grid column.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_x` and `out_y` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_req | input | 1 | Input event request, held until acknowledged |
| ev_x | input | IN_AW | Input event column in the input plane |
| ev_y | input | IN_AW | Input event row in the input plane |
| ev_ack | output | 1 | One-cycle acknowledge of an accepted event |
| kw_en | input | 1 | Kernel weight write enable |
| kw_row | input | clog2(KER_W) | Kernel row to write |
| kw_col | input | clog2(KER_W) | Kernel column to write |
| kw_data | input | WGT_W | Signed weight to write |
| out_valid | output | 1 | An output event is presented |
| out_x | output | clog2(ARR_W) | Grid column of the presented event |
| out_y | output | clog2(ARR_W) | Grid row of the presented event |
| out_ready | input | 1 | Consumer takes the presented event |

## Verification
The properties assume that an input request is a level held until its acknowledge. They also assume that the kernel is not rewritten while an event is being copied. Output stability under stall and the no-refire rule rely on the controller not integrating while an output event waits. The stimulus respects both conditions: it writes weights only between events, holds the request until the acknowledge, and raises a harmless out-of-grid request during a stall. It sweeps every input address of a small 8x8 grid, 4x4 kernel configuration and predicts every output event arithmetically.

// File: rtl/conv_pkg.sv
package conv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CALC,
        ST_ROW,
        ST_INTEG
    } conv_state_e;
endpackage

// File: rtl/conv_kernel_store.sv
module conv_kernel_store #(
    parameter int KER_W = 32,
    parameter int WGT_W = 4,
    parameter int ARR_W = 32,
    parameter int SW    = 9,
    localparam int KW   = $clog2(KER_W)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [KW-1:0]            wr_row,
    input  logic [KW-1:0]            wr_col,
    input  logic [WGT_W-1:0]         wr_data,
    input  logic [KW-1:0]            rd_row,
    input  logic signed [SW-1:0]     col_base,
    output logic [ARR_W*WGT_W-1:0]   row_wgt
);
    logic [WGT_W-1:0] mem_q [KER_W][KER_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < KER_W; i++)
                for (int j = 0; j < KER_W; j++)
                    mem_q[i][j] <= '0;
        end else if (wr_en) begin
            mem_q[wr_row][wr_col] <= wr_data;
        end
    end

    // Shift the selected kernel row onto grid columns; drop what falls outside.
    for (genvar c = 0; c < ARR_W; c++) begin : g_col
        logic signed [SW-1:0] kc;
        assign kc = $signed(SW'(c)) - col_base;
        assign row_wgt[c*WGT_W +: WGT_W] =
            (!kc[SW-1] && (kc < $signed(SW'(KER_W)))) ? mem_q[rd_row][KW'(kc)] : '0;
    end
endmodule

// File: rtl/conv_pixel_grid.sv
module conv_pixel_grid #(
    parameter int ARR_W  = 32,
    parameter int WGT_W  = 4,
    parameter int ACC_W  = 6,
    parameter int THRESH = 16,
    localparam int AXW   = $clog2(ARR_W),
    localparam int NPIX  = ARR_W * ARR_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load_en,
    input  logic [AXW-1:0]         load_row,
    input  logic [ARR_W*WGT_W-1:0] row_wgt,
    input  logic                   integ_en,
    input  logic                   clr_en,
    input  logic [2*AXW-1:0]       clr_idx,
    output logic [NPIX-1:0]        fire
);
    localparam logic signed [ACC_W:0]   SAT_HI = (ACC_W+1)'(THRESH);
    localparam logic signed [ACC_W:0]   SAT_LO = -SAT_HI;
    localparam logic signed [ACC_W-1:0] TH_A   = ACC_W'(THRESH);

    for (genvar r = 0; r < ARR_W; r++) begin : g_row
        for (genvar c = 0; c < ARR_W; c++) begin : g_pix
            localparam int IDX = r * ARR_W + c;
            logic [WGT_W-1:0]        wgt_d, wgt_q;
            logic signed [ACC_W-1:0] acc_d, acc_q, base;
            logic signed [ACC_W:0]   sum;

            always_comb begin
                base  = (clr_en && clr_idx == (2*AXW)'(IDX)) ? '0 : acc_q;
                sum   = $signed({base[ACC_W-1], base})
                      + $signed({{(ACC_W+1-WGT_W){wgt_q[WGT_W-1]}}, wgt_q});
                acc_d = base;
                wgt_d = wgt_q;
                if (integ_en) begin
                    if (sum > SAT_HI)      acc_d = ACC_W'(SAT_HI);
                    else if (sum < SAT_LO) acc_d = ACC_W'(SAT_LO);
                    else                   acc_d = ACC_W'(sum);
                    wgt_d = '0;
                end else if (load_en && load_row == AXW'(r)) begin
                    wgt_d = row_wgt[c*WGT_W +: WGT_W];
                end
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    wgt_q <= '0;
                    acc_q <= '0;
                end else begin
                    wgt_q <= wgt_d;
                    acc_q <= acc_d;
                end
            end

            assign fire[IDX] = (acc_q >= TH_A);
        end
    end
endmodule

// File: rtl/conv_fire_pick.sv
module conv_fire_pick #(
    parameter int N  = 1024,
    parameter int IW = 10
) (
    input  logic [N-1:0]  req,
    output logic          valid,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--)
            if (req[i]) idx = IW'(i);
        valid = |req;
    end
endmodule

// File: rtl/conv_event_array.sv
module conv_event_array
    import conv_pkg::*;
#(
    parameter int ARR_W  = 32,
    parameter int KER_W  = 32,
    parameter int IN_AW  = 7,
    parameter int WGT_W  = 4,
    parameter int ACC_W  = 6,
    parameter int THRESH = 16,
    localparam int AXW   = $clog2(ARR_W),
    localparam int KW    = $clog2(KER_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ev_req,
    input  logic [IN_AW-1:0] ev_x,
    input  logic [IN_AW-1:0] ev_y,
    output logic             ev_ack,
    input  logic             kw_en,
    input  logic [KW-1:0]    kw_row,
    input  logic [KW-1:0]    kw_col,
    input  logic [WGT_W-1:0] kw_data,
    output logic             out_valid,
    output logic [AXW-1:0]   out_x,
    output logic [AXW-1:0]   out_y,
    input  logic             out_ready
);
    localparam int SW   = IN_AW + 2;
    localparam int NPIX = ARR_W * ARR_W;
    localparam int OFF  = ((1 << IN_AW) - ARR_W) / 2;
    localparam logic signed [SW-1:0] SHIFT    = SW'(OFF + KER_W / 2);
    localparam logic signed [SW-1:0] LAST_ROW = SW'(ARR_W - 1);
    localparam logic signed [SW-1:0] KSPAN    = SW'(KER_W - 1);

    typedef struct packed {
        conv_state_e          st;
        logic                 ack;
        logic [IN_AW-1:0]     ex;
        logic [IN_AW-1:0]     ey;
        logic signed [SW-1:0] rbase;
        logic signed [SW-1:0] cbase;
        logic [AXW-1:0]       row;
        logic [AXW-1:0]       last;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic signed [SW-1:0]   top_s, bot_s;
    logic [ARR_W*WGT_W-1:0] row_wgt;
    logic [NPIX-1:0]        fire;
    logic [2*AXW-1:0]       pick_idx;
    logic [KW-1:0]          rd_row;

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.ack = 1'b0;
        top_s     = ctl_q.rbase;
        bot_s     = ctl_q.rbase + KSPAN;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (ev_req && !ctl_q.ack && !out_valid) begin
                    ctl_d.ex  = ev_x;
                    ctl_d.ey  = ev_y;
                    ctl_d.ack = 1'b1;
                    ctl_d.st  = ST_CALC;
                end
            end
            ST_CALC: begin
                ctl_d.rbase = $signed({2'b00, ctl_q.ey}) - SHIFT;
                ctl_d.cbase = $signed({2'b00, ctl_q.ex}) - SHIFT;
                top_s       = ctl_d.rbase;
                bot_s       = ctl_d.rbase + KSPAN;
                if (top_s > LAST_ROW || bot_s[SW-1]) begin
                    ctl_d.st = ST_IDLE;
                end else begin
                    ctl_d.row  = top_s[SW-1] ? '0 : AXW'(top_s);
                    ctl_d.last = (bot_s > LAST_ROW) ? AXW'(ARR_W - 1) : AXW'(bot_s);
                    ctl_d.st   = ST_ROW;
                end
            end
            ST_ROW: begin
                if (ctl_q.row == ctl_q.last) ctl_d.st  = ST_INTEG;
                else                         ctl_d.row = ctl_q.row + 1'b1;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '{st: ST_IDLE, default: '0};
        else     ctl_q <= ctl_d;
    end

    assign ev_ack = ctl_q.ack;
    assign rd_row = KW'(SW'(ctl_q.row) - ctl_q.rbase);

    conv_kernel_store #(
        .KER_W(KER_W), .WGT_W(WGT_W), .ARR_W(ARR_W), .SW(SW)
    ) u_kernel (
        .clk(clk), .rst(rst),
        .wr_en(kw_en), .wr_row(kw_row), .wr_col(kw_col), .wr_data(kw_data),
        .rd_row(rd_row), .col_base(ctl_q.cbase), .row_wgt(row_wgt)
    );

    conv_pixel_grid #(
        .ARR_W(ARR_W), .WGT_W(WGT_W), .ACC_W(ACC_W), .THRESH(THRESH)
    ) u_grid (
        .clk(clk), .rst(rst),
        .load_en(ctl_q.st == ST_ROW), .load_row(ctl_q.row), .row_wgt(row_wgt),
        .integ_en(ctl_q.st == ST_INTEG),
        .clr_en(out_valid && out_ready), .clr_idx(pick_idx),
        .fire(fire)
    );

    conv_fire_pick #(.N(NPIX), .IW(2*AXW)) u_pick (
        .req(fire), .valid(out_valid), .idx(pick_idx)
    );

    assign out_y = pick_idx[2*AXW-1:AXW];
    assign out_x = pick_idx[AXW-1:0];
endmodule

// File: rtl/conv_event_array_chk.sv
module conv_event_array_chk #(
    parameter int AXW = 5
) (
    input logic           clk,
    input logic           rst,
    input logic           ev_req,
    input logic           ev_ack,
    input logic           out_valid,
    input logic           out_ready,
    input logic [AXW-1:0] out_x,
    input logic [AXW-1:0] out_y
);
    assert_ack_needs_req_R2: assert property (@(posedge clk) disable iff (rst)
        ev_ack |-> $past(ev_req));

    assert_ack_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        ev_ack |=> !ev_ack);

    assert_no_ack_while_pending_R2: assert property (@(posedge clk) disable iff (rst)
        ev_ack |-> !$past(out_valid));

    assert_hold_on_stall_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_x) && $stable(out_y)));

    assert_no_refire_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready) |=>
            !(out_valid && out_x == $past(out_x) && out_y == $past(out_y)));
endmodule

bind conv_event_array conv_event_array_chk #(.AXW(AXW)) u_chk (
    .clk(clk), .rst(rst), .ev_req(ev_req), .ev_ack(ev_ack),
    .out_valid(out_valid), .out_ready(out_ready), .out_x(out_x), .out_y(out_y)
);

// File: tb/conv_event_array_test.sv
module conv_event_array_test;
    localparam int ARR = 8, KER = 4, IAW = 4, WW = 4, AW = 6, TH = 8;
    localparam int OFF = ((1 << IAW) - ARR) / 2, KC = KER / 2;

    logic clk = 1'b0, rst = 1'b1;
    always #5 clk = ~clk;

    logic           ev_req = 0, ev_ack, kw_en = 0, out_valid, out_ready = 0;
    logic [IAW-1:0] ev_x = '0, ev_y = '0;
    logic [1:0]     kw_row = '0, kw_col = '0;
    logic [WW-1:0]  kw_data = '0;
    logic [2:0]     out_x, out_y;

    conv_event_array #(.ARR_W(ARR), .KER_W(KER), .IN_AW(IAW), .WGT_W(WW),
                       .ACC_W(AW), .THRESH(TH)) uut (
        .clk(clk), .rst(rst), .ev_req(ev_req), .ev_x(ev_x), .ev_y(ev_y),
        .ev_ack(ev_ack), .kw_en(kw_en), .kw_row(kw_row), .kw_col(kw_col),
        .kw_data(kw_data), .out_valid(out_valid), .out_x(out_x), .out_y(out_y),
        .out_ready(out_ready));

    int checks = 0, fails = 0, cyc = 0;
    int kmod[KER][KER];
    int amod[ARR][ARR];
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic write_k(input int r, input int c, input int w);
        @(negedge clk);
        kw_en = 1; kw_row = 2'(r); kw_col = 2'(c); kw_data = 4'(w);
        kmod[r][c] = w;
        @(negedge clk);
        kw_en = 0;
    endtask

    task automatic model_event(input int x, input int y);
        for (int py = 0; py < ARR; py++)
            for (int px = 0; px < ARR; px++) begin
                int kr = py + OFF - y + KC;
                int kc = px + OFF - x + KC;
                if (kr >= 0 && kr < KER && kc >= 0 && kc < KER) begin
                    int a = amod[py][px] + kmod[kr][kc];
                    if (a > TH) a = TH;
                    if (a < -TH) a = -TH;
                    amod[py][px] = a;
                end
            end
    endtask

    task automatic send_event(input int x, input int y);
        @(negedge clk);
        ev_x = 4'(x); ev_y = 4'(y); ev_req = 1;
        @(negedge clk);
        chk(ev_ack == 1'b1, "R2 ack", ev_ack, 1);
        ev_req = 0;
        model_event(x, y);
        repeat (10) @(negedge clk);
    endtask

    task automatic drain(input string tag);
        int er[$], ec[$];
        for (int py = 0; py < ARR; py++)
            for (int px = 0; px < ARR; px++)
                if (amod[py][px] >= TH) begin er.push_back(py); ec.push_back(px); end
        if (er.size() == 0) begin
            chk(out_valid == 1'b0, {tag, " R7 idle"}, out_valid, 0);
        end else begin
            // Harmless request (kernel lands fully off-grid) raised during a stall.
            ev_x = '0; ev_y = '0; ev_req = 1;
            repeat (3) begin
                @(negedge clk);
                chk(out_valid && out_x == 3'(ec[0]) && out_y == 3'(er[0]),
                    "R9 stall", int'({out_y, out_x}), er[0] * ARR + ec[0]);
                chk(ev_ack == 1'b0, "R2 held off", ev_ack, 0);
            end
            out_ready = 1;
            for (int i = 0; i < er.size(); i++) begin
                chk(out_valid && out_x == 3'(ec[i]) && out_y == 3'(er[i]),
                    {tag, " R8 order"}, int'({out_valid, out_y, out_x}),
                    64 + er[i] * ARR + ec[i]);
                amod[er[i]][ec[i]] = 0;
                @(negedge clk);
            end
            out_ready = 0;
            chk(out_valid == 1'b0, {tag, " R7 drained"}, out_valid, 0);
            while (!ev_ack) @(negedge clk);
            ev_req = 0;
            repeat (4) @(negedge clk);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        finish_run();
    end

    initial begin
        int ys[6] = '{8, 0, 3, 15, 13, 8};
        int gap[5] = '{7, 2, 4, 2, 4};
        int t[6];
        for (int r = 0; r < KER; r++) for (int c = 0; c < KER; c++) kmod[r][c] = 0;
        for (int r = 0; r < ARR; r++) for (int c = 0; c < ARR; c++) amod[r][c] = 0;

        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "reset out_valid", out_valid, 0);
        chk(ev_ack == 1'b0, "reset ev_ack", ev_ack, 0);
        rst = 0;
        repeat (2) @(negedge clk);

        // R5: back-to-back events with req held, zero kernel (R1 reset value).
        ev_x = 4'd8; ev_y = 4'(ys[0]); ev_req = 1;
        for (int i = 0; i < 6; i++) begin
            do @(negedge clk); while (!ev_ack);
            t[i] = cyc;
            if (i < 5) ev_y = 4'(ys[i + 1]);
        end
        ev_req = 0;
        for (int i = 0; i < 5; i++)
            chk(t[i + 1] - t[i] == gap[i], "R5 spacing", t[i + 1] - t[i], gap[i]);
        repeat (10) @(negedge clk);
        chk(out_valid == 1'b0, "R1 zero kernel", out_valid, 0);

        // R1, R3, R4: mixed-sign kernel swept over every input address.
        for (int r = 0; r < KER; r++)
            for (int c = 0; c < KER; c++)
                write_k(r, c, ((r * 5 + c * 3 + 1) % 16) - 8);
        for (int y = 0; y < (1 << IAW); y++)
            for (int x = 0; x < (1 << IAW); x++) begin
                send_event(x, y);
                drain("R3,R4");
            end

        // R6: drive to the floor, then climb back with positive weights.
        for (int r = 0; r < KER; r++) for (int c = 0; c < KER; c++) write_k(r, c, -8);
        repeat (4) begin send_event(8, 8); drain("R6"); end
        for (int r = 0; r < KER; r++) for (int c = 0; c < KER; c++) write_k(r, c, 7);
        repeat (3) begin send_event(8, 8); drain("R6"); end
        send_event(3, 12); drain("R6");
        send_event(3, 12); drain("R6");

        finish_run();
    end
endmodule